// File: doc/BRIEF.md
# Dual-Port Bank Arbiter and Monitor Router

This block is the control core shared by two serial EEPROM slave front ends and one memory of two banks. In dual-port operation each front end owns its own bank and both may read at once. In single-port operation only front end 0 is served, and an external pin picks which bank it reaches. The block also steers one front end's clock and data lines onto a monitor tap, or releases that tap.

Writes need exclusive use of the memory. Each front end reports when a transaction starts and stops, when it has seen a write command addressed to it, and when the low bit of the first data byte has arrived. The first front end to reach that bit becomes the write owner. The other front end is refused for reads and writes until the owner's internal write timer has finished. A transaction that was refused stays refused until that front end sees its next START.

The mode and bank pins are asynchronous. They pass through synchronizers and are applied only while neither front end has a transaction open.

Top module: `dpbank_router`

## Requirements
- R1: With the mode pin low (dual mode), `bank_sel_o` is 2'b10 (bit p is the bank for port p). With no write owner, both bits of `ack_en_o` are 1, including while both ports have transactions open at the same time.
- R2: With the mode pin high (single mode), `bank_sel_o[0]` equals the applied bank pin and `bank_sel_o[1]` is 1. `ack_en_o[1]` is 0. Start, write-command and D0 strobes on port 1 grant no ownership, and `lock_o` stays 2'b00.
- R3: A D0 strobe on an enabled, unrefused port that has a write command pending in its open transaction makes that port the owner on the next clock edge. `wr_own_o` shows the owner one-hot, `lock_o` flags the other port in dual mode, and the other port's `ack_en_o` is 0. Later D0 strobes from either port do not change the owner.
- R4: If both eligible ports present D0 in the same cycle, port 0 becomes the owner.
- R5: A port that has a transaction open while it is locked is refused (`ack_en_o` 0) for the rest of that transaction, even after the lock is released. The refusal is cleared by that port's next START that occurs while it is not locked.
- R6: After the owner's STOP, the write cycle is held if `busy_i` of the owner is 1 in the cycle after STOP. It ends on the edge that samples that busy low, so `lock_o` and `wr_own_o` read 0 from the cycle after busy deasserts. If busy is 0 in the cycle after STOP, ownership ends on that edge.
- R7: With `mon_en_i` high, `mon_oe_o` is 1 and `mon_scl_o`/`mon_sda_o` copy the selected port. `mon_src_o` is the applied bank pin in dual mode and 0 in single mode.
- R8: With `mon_en_i` low, `mon_oe_o` is 0 (monitor lines high impedance) and both monitor lines read 1.
- R9: The mode and bank pins pass through a synchronizer of `SYNC_STAGES` flops. The applied configuration updates only on an edge where neither port has a transaction open and no START is arriving. A pin change made during an open transaction has no effect until after its STOP.
- R10: A D0 strobe on a port with no write command in its current transaction grants no ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| single_mode_i | input | 1 | Mode pin, asynchronous: 0 dual, 1 single |
| bank_pin_i | input | 1 | Bank / monitor-port select pin, asynchronous |
| mon_en_i | input | 1 | Monitor tap enable |
| scl_i | input | 2 | Clock line of each port, for the monitor tap |
| sda_i | input | 2 | Data line of each port, for the monitor tap |
| start_i | input | 2 | One-cycle START detected, per port |
| stop_i | input | 2 | One-cycle STOP detected, per port |
| wr_cmd_i | input | 2 | One-cycle strobe: write command addressed to this device |
| d0_i | input | 2 | One-cycle strobe: D0 of first data byte received |
| busy_i | input | 2 | Memory write timer busy, per port |
| bank_sel_o | output | 2 | Bank reached by each port |
| ack_en_o | output | 2 | Port may acknowledge and access memory |
| lock_o | output | 2 | Port is locked out by the other port's write |
| wr_own_o | output | 2 | Port owns the write, one-hot |
| mon_oe_o | output | 1 | Monitor lines driven (0 = high impedance) |
| mon_src_o | output | 1 | Port mirrored on the monitor |
| mon_scl_o | output | 1 | Monitor clock |
| mon_sda_o | output | 1 | Monitor data |

## Verification
Several properties are checked on every cycle. A locked port never has access enabled. The applied configuration never moves while a transaction is open. The owner is kept for the whole write cycle, and a tie resolves to port 0. A refusal persists until START, and the exit edges of the write cycle after a low busy are also checked each cycle. Other behaviour only shows up in the bench scenarios. These include the full ordering of START, write command, D0, STOP and busy across both ports, and a refusal that outlives its lock. They also cover mode and bank pins changed mid-transaction, monitor steering in each mode, and port 1 traffic that is ignored in single mode.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
    localparam int NPORT = 2;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_DATA = 2'd1,
        OWN_WAIT = 2'd2,
        OWN_BUSY = 2'd3
    } own_st_e;

    typedef struct packed {
        logic single;
        logic bank;
    } cfg_t;
endpackage

// File: rtl/dpb_sync.sv
module dpb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.pipe[STAGES-1];
endmodule

// File: rtl/dpb_cfg.sv
module dpb_cfg
    import dpb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic single_pin_i,
    input  logic bank_pin_i,
    input  logic bus_idle_i,
    output cfg_t cfg_o
);
    logic [1:0] pins_sync;

    dpb_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({single_pin_i, bank_pin_i}),
        .sync_o (pins_sync)
    );

    typedef struct packed {
        cfg_t cfg;
    } cfg_s;

    cfg_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bus_idle_i) begin
            s_d.cfg.single = pins_sync[1];
            s_d.cfg.bank   = pins_sync[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o = s_q.cfg;

    // R9
    cfg_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle_i |=> $stable(s_q.cfg));
endmodule

// File: rtl/dpb_port_track.sv
module dpb_port_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic wr_cmd_i,
    input  logic lock_i,
    output logic active_o,
    output logic pend_o,
    output logic rej_o
);
    typedef struct packed {
        logic active;
        logic pend;
        logic rej;
    } trk_s;

    trk_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d = '0;
        end else if (start_i) begin
            s_d.active = 1'b1;
            s_d.pend   = 1'b0;
            s_d.rej    = lock_i;
        end else if (stop_i) begin
            s_d.active = 1'b0;
            s_d.pend   = 1'b0;
        end else begin
            if (wr_cmd_i && s_q.active) s_d.pend = 1'b1;
            if (lock_i && s_q.active)   s_d.rej  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;
    assign pend_o   = s_q.pend;
    assign rej_o    = s_q.rej;

    // R5
    rej_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rej && en_i && !start_i) |=> s_q.rej);

    // R10
    pend_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.pend && !wr_cmd_i) |=> !s_q.pend);
endmodule

// File: rtl/dpb_own_arb.sv
module dpb_own_arb
    import dpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] d0_ok_i,
    input  logic [NPORT-1:0] stop_i,
    input  logic [NPORT-1:0] busy_i,
    output logic             held_o,
    output logic             owner_o
);
    typedef struct packed {
        own_st_e st;
        logic    owner;
    } arb_s;

    arb_s s_d, s_q;
    logic own_busy;
    logic own_stop;

    assign own_busy = busy_i[s_q.owner];
    assign own_stop = stop_i[s_q.owner];

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            OWN_IDLE: begin
                if (d0_ok_i[0]) begin
                    s_d.st    = OWN_DATA;
                    s_d.owner = 1'b0;
                end else if (d0_ok_i[1]) begin
                    s_d.st    = OWN_DATA;
                    s_d.owner = 1'b1;
                end
            end
            OWN_DATA: if (own_stop) s_d.st = OWN_WAIT;
            OWN_WAIT: s_d.st = own_busy ? OWN_BUSY : OWN_IDLE;
            OWN_BUSY: if (!own_busy) s_d.st = OWN_IDLE;
            default:  s_d.st = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: OWN_IDLE, owner: 1'b0};
        else        s_q <= s_d;
    end

    assign held_o  = (s_q.st != OWN_IDLE);
    assign owner_o = s_q.owner;

    // R3
    grant_on_d0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == OWN_IDLE && d0_ok_i != '0) |=> (s_q.st == OWN_DATA));

    // R4
    tie_to_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == OWN_IDLE && d0_ok_i[0] && d0_ok_i[1]) |=> (s_q.owner == 1'b0));

    // R3
    owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != OWN_IDLE) |=> (s_q.st == OWN_IDLE || $stable(s_q.owner)));

    // R6
    release_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == OWN_BUSY || s_q.st == OWN_WAIT) && !own_busy) |=> (s_q.st == OWN_IDLE));
endmodule

// File: rtl/dpbank_router.sv
module dpbank_router
    import dpb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       single_mode_i,
    input  logic       bank_pin_i,
    input  logic       mon_en_i,
    input  logic [1:0] scl_i,
    input  logic [1:0] sda_i,
    input  logic [1:0] start_i,
    input  logic [1:0] stop_i,
    input  logic [1:0] wr_cmd_i,
    input  logic [1:0] d0_i,
    input  logic [1:0] busy_i,
    output logic [1:0] bank_sel_o,
    output logic [1:0] ack_en_o,
    output logic [1:0] lock_o,
    output logic [1:0] wr_own_o,
    output logic       mon_oe_o,
    output logic       mon_src_o,
    output logic       mon_scl_o,
    output logic       mon_sda_o
);
    cfg_t             cfg;
    logic [NPORT-1:0] port_en;
    logic [NPORT-1:0] active;
    logic [NPORT-1:0] pend;
    logic [NPORT-1:0] rej;
    logic [NPORT-1:0] lock_raw;
    logic [NPORT-1:0] d0_ok;
    logic             bus_idle;
    logic             held;
    logic             owner;

    assign port_en  = {~cfg.single, 1'b1};
    assign bus_idle = (active == '0) && ((start_i & port_en) == '0);

    dpb_cfg #(.SYNC_STAGES(SYNC_STAGES)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .single_pin_i(single_mode_i),
        .bank_pin_i  (bank_pin_i),
        .bus_idle_i  (bus_idle),
        .cfg_o       (cfg)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign lock_raw[p] = held && (owner != p[0]);
        assign d0_ok[p]    = d0_i[p] && port_en[p] && pend[p] && !rej[p];

        dpb_port_track i_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (port_en[p]),
            .start_i (start_i[p]),
            .stop_i  (stop_i[p]),
            .wr_cmd_i(wr_cmd_i[p]),
            .lock_i  (lock_raw[p]),
            .active_o(active[p]),
            .pend_o  (pend[p]),
            .rej_o   (rej[p])
        );

        assign lock_o[p]   = lock_raw[p] && port_en[p];
        assign wr_own_o[p] = held && (owner == p[0]);
        assign ack_en_o[p] = port_en[p] && !lock_raw[p] && !rej[p];

        // R3
        no_ack_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_o[p] |-> !ack_en_o[p]);
    end

    dpb_own_arb i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .d0_ok_i(d0_ok),
        .stop_i (stop_i & port_en),
        .busy_i (busy_i),
        .held_o (held),
        .owner_o(owner)
    );

    assign bank_sel_o = cfg.single ? {1'b1, cfg.bank} : 2'b10;
    assign mon_src_o  = cfg.single ? 1'b0 : cfg.bank;
    assign mon_oe_o   = mon_en_i;
    assign mon_scl_o  = mon_en_i ? scl_i[mon_src_o] : 1'b1;
    assign mon_sda_o  = mon_en_i ? sda_i[mon_src_o] : 1'b1;

    // R2
    single_port1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.single |-> (!ack_en_o[1] && !wr_own_o[1]));

    // R8
    mon_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |-> (!mon_oe_o && mon_scl_o && mon_sda_o));
endmodule

// File: tb/test_dpbank_router.sv
module test_dpbank_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       single_mode_i = 1'b0, bank_pin_i = 1'b0, mon_en_i = 1'b0;
    logic [1:0] scl_i = 2'b11, sda_i = 2'b11;
    logic [1:0] start_i = '0, stop_i = '0, wr_cmd_i = '0, d0_i = '0, busy_i = '0;
    logic [1:0] bank_sel_o, ack_en_o, lock_o, wr_own_o;
    logic       mon_oe_o, mon_src_o, mon_scl_o, mon_sda_o;

    always #5 clk = ~clk;

    dpbank_router i_dpbank_router (.*);

    typedef enum int {S_BANK, S_ACK, S_LOCK, S_OWN, S_MOE, S_MSRC, S_MSCL, S_MSDA} sig_e;
    typedef struct {
        string req;
        sig_e  sig;
        int    exp;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    function automatic int actual(sig_e s);
        case (s)
            S_BANK:  return int'(bank_sel_o);
            S_ACK:   return int'(ack_en_o);
            S_LOCK:  return int'(lock_o);
            S_OWN:   return int'(wr_own_o);
            S_MOE:   return int'(mon_oe_o);
            S_MSRC:  return int'(mon_src_o);
            S_MSCL:  return int'(mon_scl_o);
            default: return int'(mon_sda_o);
        endcase
    endfunction

    // monitor: checks queued expectations just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                int   a;
                e = q.pop_front();
                a = actual(e.sig);
                total++;
                if (a != e.exp) begin
                    bad++;
                    $display("FAIL %s %s actual=%0d expected=%0d", e.req, e.sig.name(), a, e.exp);
                end
            end
        end
    end

    task automatic expect_v(string req, sig_e s, int v);
        q.push_back('{req: req, sig: s, exp: v});
    endtask

    // advance to the next falling edge and drop one-cycle strobes
    task automatic step();
        @(negedge clk);
        start_i = '0; stop_i = '0; wr_cmd_i = '0; d0_i = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        step();
        expect_v("R1 reset", S_BANK, 2); expect_v("R1 reset", S_ACK, 3);
        expect_v("R1 reset", S_LOCK, 0); expect_v("R1 reset", S_OWN, 0);
        expect_v("R8 reset", S_MOE, 0); expect_v("R8 reset", S_MSCL, 1);

        // concurrent reads, D0 without write command
        step(); start_i = 2'b11;
        step(); wr_cmd_i = 2'b10;
        step(); d0_i = 2'b01;
        expect_v("R10", S_OWN, 0); expect_v("R10", S_LOCK, 0);
        expect_v("R1 both read", S_ACK, 3);
        step(); stop_i = 2'b11;
        idle(2);

        // single owner write with busy timer
        step(); start_i = 2'b01;
        step(); wr_cmd_i = 2'b01;
        step(); d0_i = 2'b01;
        expect_v("R3", S_OWN, 1); expect_v("R3", S_LOCK, 2); expect_v("R3", S_ACK, 1);
        step(); stop_i = 2'b01; expect_v("R6 after stop", S_LOCK, 2);
        step(); busy_i = 2'b01; expect_v("R6 busy", S_OWN, 1);
        idle(2); expect_v("R6 busy hold", S_LOCK, 2);
        step(); busy_i = 2'b00;
        expect_v("R6 release", S_LOCK, 0); expect_v("R6 release", S_OWN, 0);
        expect_v("R6 release", S_ACK, 3);
        step();

        // owner write with no busy (refused write)
        step(); start_i = 2'b01;
        step(); wr_cmd_i = 2'b01;
        step(); d0_i = 2'b01; expect_v("R3", S_LOCK, 2);
        step(); stop_i = 2'b01; expect_v("R6 wait", S_LOCK, 2);
        step(); expect_v("R6 no busy", S_LOCK, 0); expect_v("R6 no busy", S_OWN, 0);
        step();

        // tie, then refusal that outlives the lock
        step(); start_i = 2'b11;
        step(); wr_cmd_i = 2'b11;
        step(); d0_i = 2'b11;
        expect_v("R4 tie", S_OWN, 1); expect_v("R4 tie", S_LOCK, 2); expect_v("R4 tie", S_ACK, 1);
        step();
        step(); stop_i = 2'b01;
        step(); busy_i = 2'b01;
        step();
        step(); busy_i = 2'b00;
        expect_v("R6", S_LOCK, 0); expect_v("R5 still refused", S_ACK, 1);
        step(); expect_v("R5 still refused", S_ACK, 1);
        step(); stop_i = 2'b10; expect_v("R5 after stop", S_ACK, 1);
        step(); start_i = 2'b10; expect_v("R5 cleared at start", S_ACK, 3);
        step(); stop_i = 2'b10;
        step();

        // port 1 wins first, later D0 from port 0 ignored
        step(); start_i = 2'b11;
        step(); wr_cmd_i = 2'b11;
        step(); d0_i = 2'b10;
        expect_v("R3 port1", S_OWN, 2); expect_v("R3 port1", S_LOCK, 1); expect_v("R3 port1", S_ACK, 2);
        step(); d0_i = 2'b01; expect_v("R3 kept", S_OWN, 2);
        step(); stop_i = 2'b11;
        step(); expect_v("R6 no busy", S_LOCK, 0);
        step();

        // mode change held while a transaction is open
        step(); start_i = 2'b01;
        step(); single_mode_i = 1'b1; bank_pin_i = 1'b1;
        idle(5); expect_v("R9 held", S_BANK, 2); expect_v("R9 held", S_ACK, 3);
        step(); stop_i = 2'b01;
        idle(3); expect_v("R9 applied", S_BANK, 3); expect_v("R2 single", S_ACK, 1);

        // single mode: port 1 ignored, port 0 owns without locking port 1
        step(); start_i = 2'b10;
        step(); wr_cmd_i = 2'b10;
        step(); d0_i = 2'b10;
        expect_v("R2 port1 ignored", S_OWN, 0); expect_v("R2 port1 ignored", S_LOCK, 0);
        expect_v("R2", S_ACK, 1);
        step(); start_i = 2'b01;
        step(); wr_cmd_i = 2'b01;
        step(); d0_i = 2'b01; expect_v("R2 owner", S_OWN, 1); expect_v("R2 no lock", S_LOCK, 0);
        step(); stop_i = 2'b01;
        step(); expect_v("R6", S_OWN, 0);
        step(); bank_pin_i = 1'b0;
        idle(4); expect_v("R2 bank0", S_BANK, 2); expect_v("R2 bank0", S_ACK, 1);

        // monitor steering
        step(); mon_en_i = 1'b1; scl_i = 2'b10; sda_i = 2'b01;
        expect_v("R7 single", S_MOE, 1); expect_v("R7 single", S_MSRC, 0);
        expect_v("R7 single", S_MSCL, 0); expect_v("R7 single", S_MSDA, 1);
        step(); bank_pin_i = 1'b1;
        idle(4); expect_v("R7 single bank1", S_MSRC, 0); expect_v("R2 bank1", S_BANK, 3);
        step(); single_mode_i = 1'b0;
        idle(4);
        expect_v("R7 dual port1", S_MSRC, 1); expect_v("R7 dual port1", S_MSCL, 1);
        expect_v("R7 dual port1", S_MSDA, 0); expect_v("R1 back to dual", S_BANK, 2);
        step(); bank_pin_i = 1'b0;
        idle(4); expect_v("R7 dual port0", S_MSRC, 0); expect_v("R7 dual port0", S_MSCL, 0);
        step(); mon_en_i = 1'b0;
        expect_v("R8 off", S_MOE, 0); expect_v("R8 off", S_MSCL, 1); expect_v("R8 off", S_MSDA, 1);
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule